// File: doc/BRIEF.md
# Two-Pattern Scan Delay-Test Sequencer

This block is a chain of mux-D scan cells with a sequencer that applies one two-pattern delay test for each start request. The chain contents drive a combinational block under test through `func_out`. The block's response comes back on `func_in`. A test has four phases:

- **Load:** serially shift an initialisation pattern into the chain.
- **Launch:** form the second pattern in the chain.
- **Capture:** capture the block's reaction to the second pattern.
- **Unload:** serially shift the captured response out on `scan_out`.

The second pattern can be formed in one of two ways, selected per test:

- **Broadside:** the chain captures the block's response to the first pattern, and that response becomes the second pattern.
- **Skewed load:** the chain shifts one more position, so the second pattern is the first pattern moved one cell along the chain. In this mode, neighbouring cells of the second pattern are tied to each other through the shift, so not every pattern pair can be produced.

While no test runs, the chain acts as ordinary functional state and loads `func_in` on every cycle. The scan enable is a registered output and changes only at clock edges. A one-cycle `done` pulse marks the end of each test.

Top module: `scan_launch_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `scan_en` and `done` are 0 and every chain cell is 0.
- R2: In every cycle where `scan_en` is 0, every cell loads its `func_in` bit in parallel at the next edge. `func_out[i]` always shows cell i.
- R3: In every cycle where `scan_en` is 1, cell 0 loads `scan_in` and cell i loads cell i-1 at the next edge. `scan_out` always shows cell CHAIN_LEN-1.
- R4: A `start` sampled high while idle begins a test. `scan_en` is 1 from the next cycle for exactly CHAIN_LEN load shifts. After those shifts, `func_out[i]` equals the bit driven on `scan_in` at load step CHAIN_LEN-1-i, counting steps from 0.
- R5: With `mode_sel` = 0 (broadside), the launch cycle has `scan_en` = 0. The chain takes `func_in`, so the second pattern is the block's response to the first pattern.
- R6: With `mode_sel` = 1 (skewed load), the launch cycle has `scan_en` = 1. After the launch edge, cell i holds first-pattern bit i-1, and cell 0 holds the `scan_in` value presented during the launch cycle.
- R7: The cycle after launch is a single capture cycle with `scan_en` = 0, in which the chain takes the response to the second pattern.
- R8: After capture, `scan_en` is 1 for exactly CHAIN_LEN unload cycles. In unload cycle k (counting from 0), `scan_out` shows captured response bit CHAIN_LEN-1-k.
- R9: `done` is 1 for exactly the one cycle following the last unload shift, with `scan_en` = 0 in that cycle. It is 0 in every other cycle.
- R10: `mode_sel` is sampled only when a test is accepted. `start` pulses and `mode_sel` changes during a running test change neither that test nor the idle state that follows it.
- R11: A run of consecutive cycles with `scan_en` = 1 never exceeds CHAIN_LEN+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the chain and the sequencer |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one two-pattern test (taken only when idle) |
| mode_sel | input | 1 | Launch style: 0 broadside, 1 skewed load |
| scan_in | input | 1 | Serial data into cell 0 |
| func_in | input | CHAIN_LEN | Response of the block under test, one bit per cell |
| scan_out | output | 1 | Serial data from the last cell |
| func_out | output | CHAIN_LEN | Chain contents driving the block under test |
| scan_en | output | 1 | Registered shift select seen by every cell |
| done | output | 1 | One-cycle end-of-test pulse |

## Verification
The assertions assume that `func_in` is a pure function of `func_out`, settled before each edge. They also assume that `scan_in`, `start` and `mode_sel` do not change within a clock phase next to the rising edge. The bench meets these by modelling the block under test as a continuous rotate-and-XOR of `func_out`, and by changing every input only on the falling edge. The shift-run bound also assumes CHAIN_LEN is at least 2, which the default satisfies.

// File: rtl/scan_launch_pkg.sv
package scan_launch_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LOAD   = 3'd1,
        PH_LAUNCH = 3'd2,
        PH_CAPT   = 3'd3,
        PH_UNLOAD = 3'd4,
        PH_FIN    = 3'd5
    } phase_e;

    typedef enum logic {
        LAUNCH_BY_CAPTURE = 1'b0,
        LAUNCH_BY_SHIFT   = 1'b1
    } launch_e;

    typedef struct packed {
        phase_e  phase;
        launch_e mode;
        logic    scan_en;
    } seq_state_t;

endpackage

// File: rtl/scan_cell.sv
module scan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_scan,
    input  logic d_func,
    input  logic d_scan,
    output logic q
);
    logic q_d;
    logic q_q;

    always_comb begin
        q_d = sel_scan ? d_scan : d_func;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/scan_cell_chain.sv
module scan_cell_chain #(
    parameter int unsigned LEN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_scan,
    input  logic           ser_in,
    input  logic [LEN-1:0] par_in,
    output logic [LEN-1:0] cells,
    output logic           ser_out
);
    logic [LEN-1:0] link;

    assign link = {cells[LEN-2:0], ser_in};

    for (genvar gi = 0; gi < LEN; gi++) begin : g_cell
        scan_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_scan (sel_scan),
            .d_func   (par_in[gi]),
            .d_scan   (link[gi]),
            .q        (cells[gi])
        );
    end

    assign ser_out = cells[LEN-1];
endmodule

// File: rtl/shift_counter.sv
module shift_counter #(
    parameter int unsigned LIMIT = 8,
    localparam int unsigned CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        if (!run || at_end) cnt_d = '0;
        else                cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = run && at_end;
endmodule

// File: rtl/launch_seq_fsm.sv
module launch_seq_fsm
    import scan_launch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mode_sel,
    input  logic shift_last,
    output logic shift_run,
    output logic scan_en,
    output logic done
);
    seq_state_t st_d;
    seq_state_t st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase   = PH_LOAD;
                    st_d.mode    = launch_e'(mode_sel);
                    st_d.scan_en = 1'b1;
                end
            end
            PH_LOAD: begin
                if (shift_last) begin
                    st_d.phase   = PH_LAUNCH;
                    st_d.scan_en = (st_q.mode == LAUNCH_BY_SHIFT);
                end
            end
            PH_LAUNCH: begin
                st_d.phase   = PH_CAPT;
                st_d.scan_en = 1'b0;
            end
            PH_CAPT: begin
                st_d.phase   = PH_UNLOAD;
                st_d.scan_en = 1'b1;
            end
            PH_UNLOAD: begin
                if (shift_last) begin
                    st_d.phase   = PH_FIN;
                    st_d.scan_en = 1'b0;
                end
            end
            PH_FIN: begin
                st_d.phase   = PH_IDLE;
                st_d.scan_en = 1'b0;
            end
            default: begin
                st_d.phase   = PH_IDLE;
                st_d.scan_en = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase   <= PH_IDLE;
            st_q.mode    <= LAUNCH_BY_CAPTURE;
            st_q.scan_en <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_run = (st_q.phase == PH_LOAD) || (st_q.phase == PH_UNLOAD);
    assign scan_en   = st_q.scan_en;
    assign done      = (st_q.phase == PH_FIN);
endmodule

// File: rtl/scan_launch_seq.sv
module scan_launch_seq #(
    parameter int unsigned CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 mode_sel,
    input  logic                 scan_in,
    input  logic [CHAIN_LEN-1:0] func_in,
    output logic                 scan_out,
    output logic [CHAIN_LEN-1:0] func_out,
    output logic                 scan_en,
    output logic                 done
);
    logic shift_run;
    logic shift_last;
    logic sel_scan;

    launch_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_sel   (mode_sel),
        .shift_last (shift_last),
        .shift_run  (shift_run),
        .scan_en    (sel_scan),
        .done       (done)
    );

    shift_counter #(.LIMIT(CHAIN_LEN)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (shift_run),
        .last  (shift_last)
    );

    scan_cell_chain #(.LEN(CHAIN_LEN)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_scan (sel_scan),
        .ser_in   (scan_in),
        .par_in   (func_in),
        .cells    (func_out),
        .ser_out  (scan_out)
    );

    assign scan_en = sel_scan;
endmodule

// File: rtl/scan_launch_seq_chk.sv
module scan_launch_seq_chk #(
    parameter int unsigned N = 8,
    localparam int unsigned RW = $clog2(N + 3)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scan_in,
    input logic [N-1:0] func_in,
    input logic [N-1:0] func_out,
    input logic         scan_en,
    input logic         done
);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              run_q <= '0;
        else if (!scan_en)       run_q <= '0;
        else if (run_q != '1)    run_q <= run_q + 1'b1;
    end

    AST_PARALLEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> func_out == $past(func_in)); // R2
    AST_SHIFT_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> func_out[N-1:1] == $past(func_out[N-2:0])); // R3
    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> func_out[0] == $past(scan_in)); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_NOT_SHIFTING: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !scan_en); // R9
    AST_DONE_AFTER_UNLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(scan_en)); // R9
    AST_SHIFT_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(N + 1)); // R11
endmodule

bind scan_launch_seq scan_launch_seq_chk #(.N(CHAIN_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_in  (scan_in),
    .func_in  (func_in),
    .func_out (func_out),
    .scan_en  (scan_en),
    .done     (done)
);

// File: tb/scan_launch_seq_tb.sv
`timescale 1ns/1ps
module scan_launch_seq_tb;
    localparam int unsigned N = 8;
    localparam logic [N-1:0] MASK = 8'hA5;

    typedef struct packed {
        logic         md;
        logic [N-1:0] pat;
        logic         lb;
        logic         disturb;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h3C, 1'b0, 1'b0},
        '{1'b1, 8'h3C, 1'b1, 1'b0},
        '{1'b0, 8'hFF, 1'b0, 1'b0},
        '{1'b1, 8'h01, 1'b0, 1'b0},
        '{1'b1, 8'h80, 1'b1, 1'b0},
        '{1'b0, 8'h00, 1'b1, 1'b1},
        '{1'b1, 8'h96, 1'b0, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mode_sel = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] func_in;
    logic         scan_out;
    logic [N-1:0] func_out;
    logic         scan_en;
    logic         done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [N-1:0] resp(input logic [N-1:0] x);
        return {x[N-2:0], x[N-1]} ^ MASK;
    endfunction

    assign func_in = resp(func_out);

    scan_launch_seq #(.CHAIN_LEN(N)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode_sel (mode_sel),
        .scan_in  (scan_in),
        .func_in  (func_in),
        .scan_out (scan_out),
        .func_out (func_out),
        .scan_en  (scan_en),
        .done     (done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_test(input vec_t v);
        logic [N-1:0] v2;
        logic [N-1:0] rr;
        v2 = v.md ? {v.pat[N-2:0], v.lb} : resp(v.pat);
        rr = resp(v2);
        @(negedge clk);
        mode_sel = v.md;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(scan_en == 1'b1, "R4 load begins", 32'(scan_en), 32'd1);
        for (int k = 0; k < N; k++) begin
            scan_in = v.pat[N-1-k];
            if (v.disturb && k == 2) begin
                start = 1'b1;
                mode_sel = ~v.md;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(func_out == v.pat, "R4 loaded pattern", 32'(func_out), 32'(v.pat));
        check(scan_en == v.md, v.md ? "R6 launch shifts" : "R5 launch captures",
              32'(scan_en), 32'(v.md));
        scan_in = v.lb;
        @(negedge clk);
        check(func_out == v2, v.md ? "R6 second pattern" : "R5 second pattern",
              32'(func_out), 32'(v2));
        check(scan_en == 1'b0, "R7 capture cycle", 32'(scan_en), 32'd0);
        @(negedge clk);
        check(func_out == rr, "R7 captured response", 32'(func_out), 32'(rr));
        for (int k = 0; k < N; k++) begin
            check(scan_en == 1'b1, "R8 unload shifting", 32'(scan_en), 32'd1);
            check(scan_out == rr[N-1-k], "R8 unload bit", 32'(scan_out), 32'(rr[N-1-k]));
            check(done == 1'b0, "R9 no early done", 32'(done), 32'd0);
            scan_in = k[0];
            @(negedge clk);
        end
        check(done == 1'b1, "R9 done pulse", 32'(done), 32'd1);
        check(scan_en == 1'b0, "R9 idle scan_en", 32'(scan_en), 32'd0);
        @(negedge clk);
        check(done == 1'b0, "R9 done width", 32'(done), 32'd0);
        if (v.disturb) begin
            mode_sel = v.md;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(scan_en == 1'b0 && done == 1'b0, "R10 no extra test",
                      32'({scan_en, done}), 32'd0);
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] prev;
        repeat (3) @(negedge clk);
        check(scan_en == 1'b0 && done == 1'b0, "R1 reset outputs", 32'({scan_en, done}), 32'd0);
        check(func_out == '0, "R1 reset cells", 32'(func_out), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(scan_en == 1'b0 && done == 1'b0, "R1 after reset", 32'({scan_en, done}), 32'd0);
        check(scan_out == func_out[N-1], "R3 scan_out is tail", 32'(scan_out), 32'(func_out[N-1]));
        for (int k = 0; k < 3; k++) begin
            prev = func_out;
            @(negedge clk);
            check(func_out == resp(prev), "R2 idle parallel load", 32'(func_out), 32'(resp(prev)));
        end
        for (int i = 0; i < NV; i++) begin
            run_test(VECS[i]);
        end
        // R6 corner: skewed launch with both launch bits against an alternating pattern
        run_test('{1'b1, 8'h55, 1'b1, 1'b0});
        run_test('{1'b1, 8'hAA, 1'b0, 1'b0});
        // R1 reset in the middle of a load
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(scan_en == 1'b0 && func_out == '0, "R1 mid-test reset",
              32'({scan_en, func_out}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_test('{1'b0, 8'hC3, 1'b0, 1'b0});
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule